// File: doc/BRIEF.md
# Synchronous Serial Shift Port

This block moves one serial frame per start command over a three-wire synchronous link: a serial clock, a data input and a data output. It works either as the clock master, dividing the system clock to make the serial clock, or as a slave that follows an external serial clock. The receiving side brings that external clock into the system clock domain through a two-flop synchroniser. Data is sampled on the rising serial clock edge and changed on the falling edge. The clock idles low in mode 0 and high in mode 3.

Software sets the configuration and loads a transmit word. It then pulses `start`. The port drives the first outgoing bit at once, shifts 8 or 16 bits, and pulses `done` when the last bit has been sampled. The received word is presented on `rx_data` in that same cycle. A frame that completes before the previous received word was acknowledged raises a sticky overflow flag. The configuration is captured when a start is accepted, so changing it during a frame has no effect on that frame.

Top module: `sync_shift_port`

## Requirements
- R1: After reset, `busy`, `done` and `ovf` are 0 and `rx_data` is 0. While idle, `sclk_out` equals `cfg_idle_high`.
- R2: In master mode, an accepted start produces exactly 8 (`cfg_wide`=0) or 16 (`cfg_wide`=1) rising edges on `sclk_out`. Every level of `sclk_out` lasts `cfg_div`+1 clock cycles, and the first transition comes `cfg_div`+1 cycles after the cycle that accepts the start. The frame ends with `sclk_out` at its idle level: low when `cfg_idle_high`=0, high when `cfg_idle_high`=1.
- R3: `sdi` is sampled at rising serial clock edges and `sdo` changes only at falling edges. The first bit is on `sdo` from the cycle after the start is accepted. A falling edge that comes before the first rising edge of a frame (mode 3) does not advance the data.
- R4: With `cfg_lsb_first`=1, bit 0 is sent and received first. With `cfg_lsb_first`=0, bit 7 (8-bit frame) or bit 15 (16-bit frame) goes first. An 8-bit frame sends `tx_data[7:0]` and returns `rx_data[15:8]`=0.
- R5: `done` is high for exactly one cycle and `rx_data` takes the new word in that same cycle. In master mode, `done` is high in the cycle in which `sclk_out` first shows the final rising edge.
- R6: In slave mode, `sclk_in` passes through a two-flop synchroniser. `done` rises at the third clock edge after the final rising edge of `sclk_in`. Serial clock edges that arrive while no slave frame is armed are ignored: no `done`, and `rx_data` is unchanged.
- R7: `ovf` is set when a frame completes while the previous received word has not been acknowledged with `rx_ack`. It stays set until `ovf_clr` is pulsed. A completion with no unacknowledged word leaves `ovf` at 0.
- R8: A `start` while `busy` is ignored. Configuration and `tx_data` changes after an accepted start do not alter the frame in progress.
- R9: `busy` is high from the cycle after an accepted start. It falls with `done` in slave mode and in master mode 3. In master mode 0 it stays high until `sclk_out` has returned low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1: generate the serial clock, 0: follow `sclk_in` |
| cfg_lsb_first | input | 1 | 1: least significant bit first |
| cfg_wide | input | 1 | 1: 16-bit frame, 0: 8-bit frame |
| cfg_idle_high | input | 1 | 0: mode 0 (idle low), 1: mode 3 (idle high) |
| cfg_div | input | DIV_W | Master half period minus one, in clock cycles |
| start | input | 1 | Start one frame |
| tx_data | input | FRAME_W | Word to transmit |
| rx_ack | input | 1 | Acknowledge that the received word was read |
| ovf_clr | input | 1 | Clear the overflow flag |
| sclk_in | input | 1 | External serial clock (slave mode) |
| sclk_out | output | 1 | Generated serial clock (master mode) |
| sclk_oe | output | 1 | High when `sclk_out` should drive the line |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| rx_data | output | FRAME_W | Last received word |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle frame-complete pulse |
| ovf | output | 1 | Sticky receive overflow flag |

## Verification
A wrong bit counter or divider count shows within one frame, as a pulse count on `sclk_out` other than 8 or 16 or a level that lasts the wrong number of cycles. A bit-order or shift error corrupts the word the peer model collects and the `rx_data` presented with `done`, so it is caught at the end of the frame. A bad pending-word or overflow state is visible as the wrong `ovf` level right after the second unacknowledged frame. Slave-mode synchroniser errors move `done` away from its fixed three-cycle lag behind the last `sclk_in` rise.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  // per-frame settings captured when a start is accepted
  typedef struct packed {
    logic master;
    logic lsb_first;
    logic wide;
    logic idle_high;
  } ssp_cfg_t;

  localparam int SSP_SYNC_STAGES = 2;
endpackage

// File: rtl/ssp_clkgen.sv
module ssp_clkgen #(
  parameter int DIV_W = 8,
  parameter int TOG_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             idle_high,
  input  logic [DIV_W-1:0] div,
  input  logic [TOG_W-1:0] toggles,
  output logic             sclk,
  output logic             rise_stb,
  output logic             fall_stb,
  output logic             active
);
  logic             act_q, act_d;
  logic             sclk_q, sclk_d;
  logic             idle_q, idle_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [TOG_W-1:0] left_q, left_d;
  logic             tick;

  assign tick     = act_q && (cnt_q == div_q);
  assign rise_stb = tick & ~sclk_q;
  assign fall_stb = tick & sclk_q;
  assign active   = act_q;
  assign sclk     = act_q ? sclk_q : idle_high;

  always_comb begin
    act_d  = act_q;
    sclk_d = sclk_q;
    idle_d = idle_q;
    cnt_d  = cnt_q;
    div_d  = div_q;
    left_d = left_q;
    if (go && !act_q) begin
      act_d  = 1'b1;
      sclk_d = idle_high;
      idle_d = idle_high;
      cnt_d  = '0;
      div_d  = div;
      left_d = toggles;
    end else if (act_q) begin
      if (tick) begin
        cnt_d  = '0;
        sclk_d = ~sclk_q;
        left_d = left_q - TOG_W'(1);
        if (left_q == TOG_W'(1)) act_d = 1'b0;
      end else begin
        cnt_d = cnt_q + DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      sclk_q <= 1'b0;
      idle_q <= 1'b0;
      cnt_q  <= '0;
      div_q  <= '0;
      left_q <= '0;
    end else begin
      act_q  <= act_d;
      sclk_q <= sclk_d;
      idle_q <= idle_d;
      cnt_q  <= cnt_d;
      div_q  <= div_d;
      left_q <= left_d;
    end
  end

  // R2
  idle_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act_q) |-> (sclk_q == idle_q));
endmodule

// File: rtl/ssp_edge_sync.sv
module ssp_edge_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_in,
  output logic rise,
  output logic fall
);
  logic [SYNC_N:0] pipe_q, pipe_d;

  always_comb pipe_d = {pipe_q[SYNC_N-1:0], sclk_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign rise = pipe_q[SYNC_N-1] & ~pipe_q[SYNC_N];
  assign fall = ~pipe_q[SYNC_N-1] & pipe_q[SYNC_N];
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
  parameter int FRAME_W = 16,
  parameter int BIT_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               wide_in,
  input  logic               lsb_in,
  input  logic [FRAME_W-1:0] tx_in,
  input  logic               rise,
  input  logic               fall,
  input  logic               sdi,
  output logic               sdo,
  output logic               done,
  output logic [FRAME_W-1:0] rx_word,
  output logic               armed
);
  localparam int HALF = FRAME_W / 2;

  function automatic logic [FRAME_W-1:0] flip(input logic [FRAME_W-1:0] x);
    logic [FRAME_W-1:0] r;
    for (int i = 0; i < FRAME_W; i++) r[i] = x[FRAME_W-1-i];
    return r;
  endfunction

  // outgoing bit always leaves from position 0
  function automatic logic [FRAME_W-1:0] order_tx(input logic [FRAME_W-1:0] x,
                                                  input logic wide, input logic lsb);
    logic [FRAME_W-1:0] v;
    if (lsb) v = wide ? x : {{(FRAME_W-HALF){1'b0}}, x[HALF-1:0]};
    else     v = wide ? flip(x) : (flip(x) >> HALF);
    return v;
  endfunction

  // incoming bits enter at the top; first bit ends at 0 (wide) or HALF (narrow)
  function automatic logic [FRAME_W-1:0] assemble(input logic [FRAME_W-1:0] x,
                                                  input logic wide, input logic lsb);
    logic [FRAME_W-1:0] v;
    if (lsb) v = wide ? x : (x >> HALF);
    else     v = flip(x);
    return v;
  endfunction

  logic               armed_q, armed_d, pend_q, pend_d;
  logic               wide_q, wide_d, lsb_q, lsb_d, done_q, done_d;
  logic [BIT_W-1:0]   cnt_q, cnt_d;
  logic [FRAME_W-1:0] tx_q, tx_d, rx_q, rx_d, word_q, word_d;
  logic               last;

  assign last = (cnt_q == (wide_q ? BIT_W'(FRAME_W-1) : BIT_W'(HALF-1)));

  always_comb begin
    armed_d = armed_q; pend_d = pend_q; wide_d = wide_q; lsb_d = lsb_q;
    cnt_d   = cnt_q;   tx_d   = tx_q;   rx_d   = rx_q;   word_d = word_q;
    done_d  = 1'b0;
    if (load && !armed_q) begin
      armed_d = 1'b1;
      pend_d  = 1'b0;
      cnt_d   = '0;
      wide_d  = wide_in;
      lsb_d   = lsb_in;
      tx_d    = order_tx(tx_in, wide_in, lsb_in);
      rx_d    = '0;
    end else if (armed_q) begin
      if (rise) begin
        rx_d   = {sdi, rx_q[FRAME_W-1:1]};
        cnt_d  = cnt_q + BIT_W'(1);
        pend_d = 1'b1;
        if (last) begin
          armed_d = 1'b0;
          done_d  = 1'b1;
          word_d  = assemble(rx_d, wide_q, lsb_q);
        end
      end else if (fall && pend_q) begin
        tx_d   = tx_q >> 1;
        pend_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0; pend_q <= 1'b0; wide_q <= 1'b0; lsb_q <= 1'b0;
      done_q  <= 1'b0; cnt_q  <= '0;   tx_q   <= '0;   rx_q  <= '0;
      word_q  <= '0;
    end else begin
      armed_q <= armed_d; pend_q <= pend_d; wide_q <= wide_d; lsb_q <= lsb_d;
      done_q  <= done_d;  cnt_q  <= cnt_d;  tx_q   <= tx_d;   rx_q  <= rx_d;
      word_q  <= word_d;
    end
  end

  assign sdo     = tx_q[0];
  assign done    = done_q;
  assign rx_word = word_q;
  assign armed   = armed_q;

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R5
  word_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(word_q) |-> done_q);
endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port #(
  parameter int FRAME_W = 16,
  parameter int DIV_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_master,
  input  logic               cfg_lsb_first,
  input  logic               cfg_wide,
  input  logic               cfg_idle_high,
  input  logic [DIV_W-1:0]   cfg_div,
  input  logic               start,
  input  logic [FRAME_W-1:0] tx_data,
  input  logic               rx_ack,
  input  logic               ovf_clr,
  input  logic               sclk_in,
  output logic               sclk_out,
  output logic               sclk_oe,
  input  logic               sdi,
  output logic               sdo,
  output logic [FRAME_W-1:0] rx_data,
  output logic               busy,
  output logic               done,
  output logic               ovf
);
  import ssp_pkg::*;

  localparam int TOG_W = $clog2(2*FRAME_W + 1);
  localparam int BIT_W = $clog2(FRAME_W + 1);

  logic [1:0]       rsync_q;
  logic             rst_ni;
  logic             start_ok, armed, clk_active;
  logic             m_rise, m_fall, s_rise, s_fall, rise_sel, fall_sel;
  logic [TOG_W-1:0] toggles;
  ssp_cfg_t         cfg_q, cfg_d;
  logic             rx_pend_q, rx_pend_d, ovf_q, ovf_d;

  // reset asserted at once, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  assign busy     = armed | clk_active;
  assign start_ok = start & ~busy;
  assign toggles  = cfg_wide ? TOG_W'(2*FRAME_W) : TOG_W'(FRAME_W);
  assign sclk_oe  = cfg_master;

  ssp_clkgen #(.DIV_W(DIV_W), .TOG_W(TOG_W)) u_clkgen (
    .clk(clk), .rst_n(rst_ni), .go(start_ok & cfg_master), .idle_high(cfg_idle_high),
    .div(cfg_div), .toggles(toggles), .sclk(sclk_out), .rise_stb(m_rise),
    .fall_stb(m_fall), .active(clk_active));

  ssp_edge_sync #(.SYNC_N(SSP_SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_ni), .sclk_in(sclk_in), .rise(s_rise), .fall(s_fall));

  assign rise_sel = cfg_q.master ? m_rise : s_rise;
  assign fall_sel = cfg_q.master ? m_fall : s_fall;

  ssp_shifter #(.FRAME_W(FRAME_W), .BIT_W(BIT_W)) u_shift (
    .clk(clk), .rst_n(rst_ni), .load(start_ok), .wide_in(cfg_wide),
    .lsb_in(cfg_lsb_first), .tx_in(tx_data), .rise(rise_sel), .fall(fall_sel),
    .sdi(sdi), .sdo(sdo), .done(done), .rx_word(rx_data), .armed(armed));

  always_comb begin
    cfg_d = cfg_q;
    if (start_ok) cfg_d = '{master: cfg_master, lsb_first: cfg_lsb_first,
                           wide: cfg_wide, idle_high: cfg_idle_high};
    rx_pend_d = done ? 1'b1 : (rx_ack ? 1'b0 : rx_pend_q);
    ovf_d     = (done && rx_pend_q) ? 1'b1 : (ovf_clr ? 1'b0 : ovf_q);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q     <= '0;
      rx_pend_q <= 1'b0;
      ovf_q     <= 1'b0;
    end else begin
      cfg_q     <= cfg_d;
      rx_pend_q <= rx_pend_d;
      ovf_q     <= ovf_d;
    end
  end

  assign ovf = ovf_q;

  // R7
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(ovf_q) |-> $past(done && rx_pend_q));
  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy && start) |=> $stable(cfg_q));
endmodule

// File: tb/sync_shift_port_test.sv
module sync_shift_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int HP = 5;

  typedef struct packed {
    logic       master;
    logic       lsb;
    logic       wide;
    logic       mode3;
    logic [7:0] div;
    logic [15:0] tx;
    logic [15:0] peer;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{1'b1, 1'b0, 1'b0, 1'b0, 8'd1, 16'h00A5, 16'h003C},
    '{1'b1, 1'b1, 1'b1, 1'b0, 8'd0, 16'h1234, 16'hBEEF},
    '{1'b1, 1'b0, 1'b1, 1'b1, 8'd2, 16'hC3A1, 16'h5A0F},
    '{1'b1, 1'b1, 1'b0, 1'b1, 8'd3, 16'hFF81, 16'h0096},
    '{1'b0, 1'b0, 1'b1, 1'b0, 8'd0, 16'h8001, 16'h7E55},
    '{1'b0, 1'b1, 1'b0, 1'b1, 8'd0, 16'h004D, 16'h00B2},
    '{1'b0, 1'b0, 1'b0, 1'b1, 8'd0, 16'h0011, 16'h0080}
  };

  logic clk, rst_n, cfg_master, cfg_lsb_first, cfg_wide, cfg_idle_high;
  logic [7:0] cfg_div;
  logic start, rx_ack, ovf_clr, sclk_in, sdi;
  logic [15:0] tx_data, rx_data;
  logic sclk_out, sclk_oe, sdo, busy, done, ovf;
  int checks = 0, bad = 0;
  bit finished = 0;

  sync_shift_port uut (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_lsb_first(cfg_lsb_first),
    .cfg_wide(cfg_wide), .cfg_idle_high(cfg_idle_high), .cfg_div(cfg_div),
    .start(start), .tx_data(tx_data), .rx_ack(rx_ack), .ovf_clr(ovf_clr),
    .sclk_in(sclk_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe), .sdi(sdi), .sdo(sdo),
    .rx_data(rx_data), .busy(busy), .done(done), .ovf(ovf));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int bitpos(vec_t v, int i);
    int n = v.wide ? 16 : 8;
    return v.lsb ? i : n - 1 - i;
  endfunction

  function automatic logic [15:0] fit(vec_t v, logic [15:0] x);
    return v.wide ? x : {8'h00, x[7:0]};
  endfunction

  task automatic pulse_ack_clr();
    rx_ack = 1'b1; ovf_clr = 1'b1; tick();
    rx_ack = 1'b0; ovf_clr = 1'b0; tick();
  endtask

  // one frame; the bench plays the opposite end of the link
  task automatic run_vec(input vec_t v, input bit poke);
    int n, rises, dones, lag, since, last, bad_iv, idx, limit;
    logic [15:0] cap, rxv;
    logic prev, busy_at;
    bit pendp;
    n = v.wide ? 16 : 8;
    rises = 0; dones = 0; lag = -1; since = 0; last = 0; bad_iv = 0; idx = 0;
    cap = '0; rxv = '0; busy_at = 1'b0; pendp = 1'b0;
    cfg_master = v.master; cfg_lsb_first = v.lsb; cfg_wide = v.wide;
    cfg_idle_high = v.mode3; cfg_div = v.div; tx_data = v.tx;
    sclk_in = v.mode3; sdi = v.peer[bitpos(v, 0)];
    repeat (6) tick();
    start = 1'b1; tick(); start = 1'b0;
    if (v.master) begin
      prev = v.mode3;
      limit = 2 * n * (int'(v.div) + 1) + 8;
      for (int k = 0; k < limit; k++) begin
        if (poke && k == 2) begin
          start = 1'b1; tx_data = ~v.tx; cfg_lsb_first = ~v.lsb;
        end
        if (poke && k == 3) start = 1'b0;
        since++;
        if (sclk_out !== prev) begin
          if (k - last != int'(v.div) + 1) bad_iv++;
          last = k;
          if (sclk_out) begin
            if (rises < n) cap[bitpos(v, rises)] = sdo;
            rises++; pendp = 1'b1; since = 0;
          end else if (pendp) begin
            idx++; pendp = 1'b0;
            if (idx < n) sdi = v.peer[bitpos(v, idx)];
          end
          prev = sclk_out;
        end
        if (done) begin dones++; rxv = rx_data; lag = since; busy_at = busy; end
        tick();
      end
      chk("R2 rising edge count", rises, n);
      chk("R2 half period length", bad_iv, 0);
      chk("R2 idle level at end", sclk_out, v.mode3);
    end else begin
      for (int i = 0; i < n; i++) begin
        sclk_in = 1'b0;
        if (i > 0) sdi = v.peer[bitpos(v, i)];
        for (int j = 0; j < HP; j++) begin
          tick(); since++;
          if (done) begin dones++; rxv = rx_data; lag = since; busy_at = busy; end
        end
        cap[bitpos(v, i)] = sdo;
        sclk_in = 1'b1; since = 0;
        for (int j = 0; j < HP; j++) begin
          tick(); since++;
          if (done) begin dones++; rxv = rx_data; lag = since; busy_at = busy; end
        end
      end
      sclk_in = v.mode3;
      for (int j = 0; j < 2 * HP; j++) begin
        tick(); since++;
        if (done) begin dones++; rxv = rx_data; lag = since; busy_at = busy; end
      end
    end
    chk("R4 R3 bits sent on sdo", cap, fit(v, v.tx));
    chk("R4 received word", rxv, fit(v, v.peer));
    chk("R5 single done pulse", dones, 1);
    chk(v.master ? "R5 done timing" : "R6 done lag after sclk_in", lag, v.master ? 0 : 3);
    chk("R9 busy when done", busy_at, v.master && !v.mode3);
    chk("R9 idle after frame", busy, 0);
    cfg_lsb_first = v.lsb; tx_data = v.tx;
  endtask

  initial begin
    logic [15:0] keep;
    int dcount;
    rst_n = 1'b0; cfg_master = 1'b0; cfg_lsb_first = 1'b0; cfg_wide = 1'b0;
    cfg_idle_high = 1'b1; cfg_div = '0; start = 1'b0; tx_data = '0;
    rx_ack = 1'b0; ovf_clr = 1'b0; sclk_in = 1'b0; sdi = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 ovf", ovf, 0);
    chk("R1 rx_data", rx_data, 0);
    chk("R1 idle high clock", sclk_out, 1);
    cfg_idle_high = 1'b0; tick();
    chk("R1 idle low clock", sclk_out, 0);

    foreach (VECS[i]) begin
      pulse_ack_clr();
      run_vec(VECS[i], 1'b0);
    end

    // R8 start during a frame is ignored
    pulse_ack_clr();
    run_vec(VECS[2], 1'b1);
    chk("R8 no overflow from ignored start", ovf, 0);

    // R7 overflow sequence
    pulse_ack_clr();
    run_vec(VECS[0], 1'b0);
    chk("R7 first frame no overflow", ovf, 0);
    run_vec(VECS[3], 1'b0);
    chk("R7 unread frame sets overflow", ovf, 1);
    repeat (5) tick();
    chk("R7 overflow is sticky", ovf, 1);
    ovf_clr = 1'b1; tick(); ovf_clr = 1'b0;
    chk("R7 overflow cleared", ovf, 0);
    rx_ack = 1'b1; tick(); rx_ack = 1'b0;
    run_vec(VECS[1], 1'b0);
    chk("R7 acknowledged word no overflow", ovf, 0);

    // R6 clock edges with no armed slave frame
    cfg_master = 1'b0; cfg_idle_high = 1'b0; sclk_in = 1'b0;
    repeat (4) tick();
    keep = rx_data; dcount = 0;
    for (int p = 0; p < 8; p++) begin
      sclk_in = 1'b1;
      for (int j = 0; j < HP; j++) begin tick(); if (done) dcount++; end
      sclk_in = 1'b0;
      for (int j = 0; j < HP; j++) begin tick(); if (done) dcount++; end
    end
    chk("R6 no done when not armed", dcount, 0);
    chk("R6 rx_data unchanged when not armed", rx_data, keep);
    chk("R6 busy stays low", busy, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      checks++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule